// File: doc/BRIEF.md
# Mode-Gated Write-Once Control Register

This block is a small bus-mapped configuration register with three stored bits. One bit shows internal bus cycles on the external pins, one asks for the external bus to stop while the chip sits in wait mode, and one takes the port E data and direction registers out of the internal map. The rules for writing it depend on the current operating mode. A normal mode takes exactly one write. A special mode discards the first write after reset and takes every later one. Reads are allowed at any time.

The stored bits are combined with a 3-bit mode code to form the effective controls. These are a visibility enable, a width select for visible internal cycles, a port E map-present flag and a bus shutdown request. The shutdown request is raised only after a drain delay that pauses while the bus reports activity. The bus sequencer, the address decoder and the port E registers themselves sit outside this block.

Top module: `mode_cfg_reg`

## Requirements
- R1: In a normal mode (mode_code[2]=0), the first write strobe after reset stores reg_wdata[0] as the visibility bit, reg_wdata[1] as the wait-stop bit and reg_wdata[2] as the emulate bit. Every later write is ignored.
- R2: In a special mode (mode_code[2]=1), the first write strobe after reset is ignored and every later write strobe is stored, using the same bit positions as R1.
- R3: After reset all three stored bits are 0 and no write has been seen. vis_en and bus_shutdown are 0, and porte_map is 1. The internal reset is released on the second clock edge after rst_n rises.
- R4: While reg_rd is 1, reg_rdata carries the stored bits in positions [2:0], with all other bits 0, in every mode and never masked by the mode. While reg_rd is 0, reg_rdata is all zero.
- R5: mode_code[1:0] selects the bus arrangement: 00 single-chip, 01 expanded narrow, 10 expanded wide, 11 treated as single-chip. mode_code[2] selects special (1) or normal (0).
- R6: vis_en is 1 only when the visibility bit is set and the mode is expanded. In normal expanded narrow mode it is always 0.
- R7: vis_wide is 1 in expanded wide mode of either variant, and in special expanded narrow mode while the visibility bit is set. It is 0 in every other case.
- R8: porte_map is 1 in single-chip mode whatever the emulate bit holds. In expanded modes it is the inverse of the emulate bit.
- R9: Wait entry is wait_req sampled 1 at an edge after being sampled 0 at the edge before. An entry arms the drain only if the wait-stop bit was already set before that edge, and it loads DRAIN_CYC. The count then drops by one at each later edge, and bus_shutdown rises once it reaches zero. With the default of 8 and no busy cycles, bus_shutdown is 1 after the eighth edge following the entry edge.
- R10: While bus_busy is 1 the drain count holds its value.
- R11: bus_shutdown falls in the same cycle that wait_req falls, and it is 0 whenever the stored wait-stop bit is 0.
- R12: A write that sets the wait-stop bit on the same edge as a wait entry does not arm the drain for that wait period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, stored bits |
| mode_code | input | 3 | Operating mode code |
| wait_req | input | 1 | Wait mode active |
| bus_busy | input | 1 | External bus cycle in progress |
| vis_en | output | 1 | Internal cycles shown on external bus |
| vis_wide | output | 1 | Visible internal cycles use 16-bit signalling |
| porte_map | output | 1 | Port E registers present in internal map |
| bus_shutdown | output | 1 | External bus shutdown request |

## Verification
A register write and a wait entry can land on the same clock edge. The write may set the wait-stop bit, or clear it while a drain is running. The bench provokes the first case on purpose, by raising wait_req in the same cycle as a write that sets the bit. It expects no shutdown for that whole wait period, and a normal drain after wait is left and entered again. A long random phase in special mode mixes writes, busy pulses, wait toggles and mode changes. Every output is compared each clock against a behavioural model that checks wait entry against the bit value stored before the edge.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;

  // Bus arrangement selected by the low two mode bits
  typedef enum logic [1:0] {
    MAP_SINGLE = 2'b00,
    MAP_NARROW = 2'b01,
    MAP_WIDE   = 2'b10,
    MAP_RSVD   = 2'b11
  } map_kind_e;

  // Stored control bits; packed order matches write-data positions
  typedef struct packed {
    logic emul;   // bit 2
    logic wstop;  // bit 1
    logic vis;    // bit 0
  } ctl_bits_t;

  localparam int CTL_W     = 3;
  localparam int MODE_W    = 3;
  localparam int SPECIAL_B = 2;

  function automatic logic mode_special(input logic [MODE_W-1:0] m);
    return m[SPECIAL_B];
  endfunction

  function automatic map_kind_e mode_map(input logic [MODE_W-1:0] m);
    return map_kind_e'(m[1:0]);
  endfunction

endpackage

// File: rtl/cfgreg_store.sv
module cfgreg_store
  import cfgreg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              special_i,
  output ctl_bits_t         bits_o,
  output logic              first_seen_o
);

  ctl_bits_t bits_q, bits_d;
  logic      first_q, first_d;
  logic      accept;

  // Next state: normal modes take the first strobe, special modes the rest
  always_comb begin
    accept  = special_i ? first_q : ~first_q;
    bits_d  = bits_q;
    first_d = first_q;
    if (wr_en_i) begin
      first_d = 1'b1;
      if (accept) bits_d = ctl_bits_t'(wdata_i[CTL_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q  <= '0;
      first_q <= 1'b0;
    end else if (wr_en_i) begin
      bits_q  <= bits_d;
      first_q <= first_d;
    end
  end

  assign bits_o       = bits_q;
  assign first_seen_o = first_q;

  AST_NORMAL_WRITE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && first_q && !special_i) |=> $stable(bits_q)); // R1
  AST_SPECIAL_FIRST_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !first_q && special_i) |=> $stable(bits_q)); // R2
  AST_SPECIAL_LATER_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && first_q && special_i) |=> (bits_q == ctl_bits_t'($past(wdata_i[CTL_W-1:0])))); // R2
  AST_FIRST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    first_q |=> first_q); // R1

endmodule

// File: rtl/cfgreg_decode.sv
module cfgreg_decode
  import cfgreg_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  ctl_bits_t         bits_i,
  output logic              vis_en_o,
  output logic              vis_wide_o,
  output logic              porte_map_o
);

  logic      special;
  map_kind_e kind;
  logic      expanded;
  logic      vis_allowed;

  always_comb begin
    special  = mode_special(mode_i);
    kind     = mode_map(mode_i);
    expanded = (kind == MAP_NARROW) || (kind == MAP_WIDE);
    unique case (kind)
      MAP_NARROW: vis_allowed = special;
      MAP_WIDE:   vis_allowed = 1'b1;
      default:    vis_allowed = 1'b0;
    endcase
    vis_en_o    = bits_i.vis & vis_allowed;
    vis_wide_o  = (kind == MAP_WIDE) | ((kind == MAP_NARROW) & special & bits_i.vis);
    porte_map_o = ~expanded | ~bits_i.emul;
  end

endmodule

// File: rtl/cfgreg_drain.sv
module cfgreg_drain #(
  parameter int DRAIN_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_i,
  input  logic busy_i,
  input  logic stop_bit_i,
  output logic shdn_o
);

  localparam int CNT_W = (DRAIN_CYC < 1) ? 1 : $clog2(DRAIN_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(DRAIN_CYC);

  logic             prev_q;
  logic             armed_q, armed_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             entry;

  always_comb begin
    entry   = wait_i & ~prev_q;
    armed_d = armed_q;
    cnt_d   = cnt_q;
    if (entry) begin
      armed_d = stop_bit_i;
      cnt_d   = LOAD;
    end else if (!wait_i) begin
      armed_d = 1'b0;
    end else if (armed_q && (cnt_q != '0) && !busy_i) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      prev_q  <= wait_i;
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end

  assign shdn_o = armed_q & (cnt_q == '0) & wait_i & stop_bit_i;

  AST_SHDN_NEEDS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_o |-> wait_i); // R11
  AST_ENTRY_NOT_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_i && !prev_q) |=> !shdn_o); // R9
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && wait_i && busy_i) |=> $stable(cnt_q)); // R10
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD); // R9

endmodule

// File: rtl/mode_cfg_reg.sv
module mode_cfg_reg
  import cfgreg_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DRAIN_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [2:0]        mode_code,
  input  logic              wait_req,
  input  logic              bus_busy,
  output logic              vis_en,
  output logic              vis_wide,
  output logic              porte_map,
  output logic              bus_shutdown
);

  localparam int SYNC_W = 2;

  logic [SYNC_W-1:0] sync_q;
  logic              rst_int_n;
  ctl_bits_t         bits;
  logic              first_seen;
  logic [CTL_W-1:0]  bits_flat;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_W-2:0], 1'b1};
  end
  assign rst_int_n = sync_q[SYNC_W-1];

  cfgreg_store #(.DATA_W(DATA_W)) u_store (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .wr_en_i      (reg_wr),
    .wdata_i      (reg_wdata),
    .special_i    (mode_special(mode_code)),
    .bits_o       (bits),
    .first_seen_o (first_seen)
  );

  cfgreg_decode u_decode (
    .mode_i      (mode_code),
    .bits_i      (bits),
    .vis_en_o    (vis_en),
    .vis_wide_o  (vis_wide),
    .porte_map_o (porte_map)
  );

  cfgreg_drain #(.DRAIN_CYC(DRAIN_CYC)) u_drain (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wait_i     (wait_req),
    .busy_i     (bus_busy),
    .stop_bit_i (bits.wstop),
    .shdn_o     (bus_shutdown)
  );

  assign bits_flat = bits;

  // Read-back of stored bits, zero-extended and gated by the strobe
  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_rd
    if (gi < CTL_W) begin : g_ctl
      assign reg_rdata[gi] = reg_rd & bits_flat[gi];
    end else begin : g_pad
      assign reg_rdata[gi] = 1'b0;
    end
  end

  AST_SINGLE_CHIP_PE: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((mode_code[1:0] == 2'b00) || (mode_code[1:0] == 2'b11)) |-> porte_map); // R8
  AST_NARROW_NORMAL_NO_VIS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode_code == 3'b001) |-> !vis_en); // R6
  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_int_n) |-> (!first_seen && !vis_en && !bus_shutdown)); // R3

endmodule

// File: tb/mode_cfg_reg_tb_top.sv
module mode_cfg_reg_tb_top;

  localparam int DATA_W    = 8;
  localparam int DRAIN_CYC = 8;
  localparam int WDOG      = 200000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0;
  logic              reg_rd = 1'b0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic [2:0]        mode_code = 3'b010;
  logic              wait_req = 1'b0;
  logic              bus_busy = 1'b0;
  logic              vis_en, vis_wide, porte_map, bus_shutdown;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  logic cmp_en = 1'b0;
  logic done   = 1'b0;

  // Behavioural model state
  logic m_seen, m_vis, m_wst, m_emu, m_arm, m_prev;
  int   m_cnt;

  always #10 clk = ~clk;

  mode_cfg_reg #(.DATA_W(DATA_W), .DRAIN_CYC(DRAIN_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mode_code(mode_code),
    .wait_req(wait_req), .bus_busy(bus_busy), .vis_en(vis_en),
    .vis_wide(vis_wide), .porte_map(porte_map), .bus_shutdown(bus_shutdown)
  );

  // Model update at each edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_seen = 0; m_vis = 0; m_wst = 0; m_emu = 0;
      m_arm = 0; m_prev = 0; m_cnt = 0;
    end else begin
      if (wait_req && !m_prev) begin          // R9, R12: uses bit before edge
        m_arm = m_wst;
        m_cnt = DRAIN_CYC;
      end else if (!wait_req) begin
        m_arm = 0;
      end else if (m_arm && m_cnt > 0 && !bus_busy) begin
        m_cnt = m_cnt - 1;                     // R10 holds when busy
      end
      if (reg_wr) begin
        if (mode_code[2] ? m_seen : !m_seen) begin   // R1, R2
          m_vis = reg_wdata[0];
          m_wst = reg_wdata[1];
          m_emu = reg_wdata[2];
        end
        m_seen = 1;
      end
      m_prev = wait_req;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (cmp_en) begin
      logic sc, nar, wid, spc;
      logic [DATA_W-1:0] e_rd;
      spc = mode_code[2];
      sc  = (mode_code[1:0] == 2'b00) || (mode_code[1:0] == 2'b11);  // R5
      nar = (mode_code[1:0] == 2'b01);
      wid = (mode_code[1:0] == 2'b10);
      e_rd = reg_rd ? DATA_W'({m_emu, m_wst, m_vis}) : '0;
      chk("R1,R2,R4 reg_rdata", int'(reg_rdata), int'(e_rd));
      chk("R6 vis_en", int'(vis_en), int'(m_vis && !sc && !(!spc && nar)));
      chk("R7 vis_wide", int'(vis_wide), int'(wid || (spc && nar && m_vis)));
      chk("R8 porte_map", int'(porte_map), int'(sc || !m_emu));
      chk("R9,R10,R11,R12 bus_shutdown", int'(bus_shutdown),
          int'(m_arm && m_cnt == 0 && wait_req && m_wst));
    end
  end

  task automatic drv(input logic wr, input logic rd, input logic [DATA_W-1:0] wd,
                     input logic [2:0] md, input logic wt, input logic bz);
    @(posedge clk); #5;
    reg_wr = wr; reg_rd = rd; reg_wdata = wd; mode_code = md;
    wait_req = wt; bus_busy = bz;
  endtask

  task automatic do_reset(input logic [2:0] md);
    cmp_en = 0;
    @(posedge clk); #5;
    reg_wr = 0; reg_rd = 1; wait_req = 0; bus_busy = 0; mode_code = md;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #5 rst_n = 1;
    repeat (3) @(posedge clk);
    #5 cmp_en = 1;
  endtask

  task automatic sweep_modes();
    for (int m = 0; m < 8; m++) begin            // R5, R6, R7, R8
      drv(0, 1, '0, 3'(m), 0, 0);
      drv(0, 0, '0, 3'(m), 0, 0);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset(3'b010);
    // R3: reset state at the ports
    #2;
    chk("R3 vis_en", int'(vis_en), 0);
    chk("R3 porte_map", int'(porte_map), 1);
    chk("R3 bus_shutdown", int'(bus_shutdown), 0);
    chk("R3 reg_rdata", int'(reg_rdata), 0);

    // R1: normal wide, first write kept, later ones dropped
    drv(1, 1, 8'h07, 3'b010, 0, 0);
    drv(0, 1, 8'h00, 3'b010, 0, 0);
    drv(1, 1, 8'h00, 3'b010, 0, 0);
    drv(1, 1, 8'h02, 3'b000, 0, 0);
    drv(0, 1, 8'h00, 3'b010, 0, 0);
    sweep_modes();

    // R9, R10, R11: drain with and without busy
    for (int i = 0; i < 12; i++) drv(0, 1, '0, 3'b010, 1, 0);
    drv(0, 1, '0, 3'b010, 0, 0);              // R11 same-cycle drop
    for (int i = 0; i < 14; i++) drv(0, 1, '0, 3'b010, 1, (i % 3) == 1);
    for (int i = 0; i < 3; i++)  drv(0, 1, '0, 3'b010, 1, 1);
    drv(0, 1, '0, 3'b010, 0, 0);

    // R2: special narrow, first write dropped, later ones kept
    do_reset(3'b101);
    drv(1, 1, 8'h07, 3'b101, 0, 0);
    drv(0, 1, 8'h00, 3'b101, 0, 0);
    drv(1, 1, 8'h01, 3'b101, 0, 0);
    drv(0, 1, 8'h00, 3'b101, 0, 0);
    sweep_modes();
    drv(1, 1, 8'hFC, 3'b101, 0, 0);           // R4 upper bits read as zero
    drv(0, 1, 8'h00, 3'b101, 0, 0);
    sweep_modes();
    // R11: stop bit clear means no shutdown
    drv(1, 1, 8'h01, 3'b101, 0, 0);
    for (int i = 0; i < 12; i++) drv(0, 1, '0, 3'b101, 1, 0);
    drv(0, 1, '0, 3'b101, 0, 0);

    // R12: write setting stop bit on the wait-entry edge
    do_reset(3'b110);
    drv(1, 1, 8'h00, 3'b110, 0, 0);           // first write, dropped
    drv(0, 1, 8'h00, 3'b110, 0, 0);
    drv(1, 1, 8'h02, 3'b110, 1, 0);
    for (int i = 0; i < 12; i++) drv(0, 1, '0, 3'b110, 1, 0);
    drv(0, 1, '0, 3'b110, 0, 0);
    for (int i = 0; i < 12; i++) drv(0, 1, '0, 3'b110, 1, 0);
    // clear the stop bit mid-drain, then set it again
    drv(0, 1, '0, 3'b110, 0, 0);
    for (int i = 0; i < 4; i++) drv(0, 1, '0, 3'b110, 1, 0);
    drv(1, 1, 8'h00, 3'b110, 1, 0);
    drv(1, 1, 8'h02, 3'b110, 1, 0);
    for (int i = 0; i < 8; i++) drv(0, 1, '0, 3'b110, 1, 0);
    drv(0, 1, '0, 3'b110, 0, 0);

    // Mixed random phase in special modes
    do_reset(3'b100);
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      drv(r[0] & r[1], r[2], r[15:8], {1'b1, r[4:3]}, r[5] | r[6] | r[7], r[16] & r[17]);
    end
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r;
      r = $urandom;
      drv(r[0] & r[1] & r[9], 1'b1, r[15:8], r[4:2], r[5] | r[6], r[16] & r[17]);
    end

    drv(0, 0, '0, 3'b010, 0, 0);
    drv(0, 0, '0, 3'b010, 0, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule